// File: doc/BRIEF.md
# Command-First Serial Register Slave

This block is the control-side serial slave of a data converter. A host on a shared four-wire serial bus selects the block with an active-low chip select. The host then drives a serial clock and data into the block, and reads data back on a separate output line. An active-low ready flag tells the host when a fresh conversion word can be read. The block runs from its own system clock. It oversamples the serial lines through synchronizers, so the serial clock must be several times slower than the system clock.

Each access is a command byte followed by a data transfer. The command byte names one of eight register slots and a direction. The data transfer that follows then moves data into or out of that slot. After the transfer ends, the block waits for a new command byte. On a parallel port, the conversion side presents a 16-bit word with a one-cycle strobe. The block raises the ready flag while it moves that word into the data register, and lowers the flag once the word is in place. A completed read of the data register raises the flag again.

Top module: `sps_top`

## Requirements
- R1: After reset, `drdy_n` is 1 and `dout_oe` is 0, and the first serial byte is decoded as a command byte.
- R2: A command byte is accepted only when bit 7 is 0. Bits 6:4 select the register slot and bit 3 picks the direction (1 = read). A byte with bit 7 set is dropped, and the byte after it is decoded as a command.
- R3: After a write command to slot 1, 2, 4, 5, 6 or 7, the next 8 bits are sampled on rising `sclk`, MSB first, and stored in that slot. A later read returns the stored value.
- R4: After a read command, the slot value is shifted out on `dout`, MSB first. The first bit is valid before the first rising edge, and each later bit changes after a falling edge. `dout_oe` is 1 only during that read phase while `cs_n` is low.
- R5: Reading slot 0 returns the command byte that selected it.
- R6: Slot 3 is the 16-bit data register. A read returns the most recently loaded conversion word. A 16-bit write to slot 3 leaves it unchanged.
- R7: In the cycle after a `conv_valid` strobe, `drdy_n` is 1 and the data register still holds the old word. One cycle later, the new word is in the data register and `drdy_n` is 0.
- R8: When all 16 bits of a data-register read have been clocked out, `drdy_n` goes to 1. A read cut short by `cs_n` leaves `drdy_n` unchanged.
- R9: Raising `cs_n` in the middle of a transfer discards the partial transfer, sets `dout_oe` to 0 and returns the block to waiting for a command byte.
- R10: Several command and data pairs can follow one another within a single `cs_n` low window. Each pair completes before the next command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for `dout`; high impedance when 0 |
| drdy_n | output | 1 | Conversion word ready, active low |
| conv_valid | input | 1 | One-cycle strobe that loads a conversion word |
| conv_data | input | 16 | Conversion word to load |

## Verification
The assertions check the ready-flag ordering on every cycle. A change of the data register must come one cycle after `drdy_n` was high, and must leave the flag low. A completed data read must set the flag high. The assertions also check that an idle chip select forces the command state, and that `dout` moves only after a falling serial edge within a read. Only the bench's scenarios can show the rest. That covers end-to-end register contents, the rejection of bad command bytes, the read-back of slot 0, ignored writes to the data register, and recovery after an aborted frame. Each of these depends on a whole sequence of serial bits.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_LOAD = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } sps_state_e;
endpackage

// File: rtl/sps_sync_edge.sv
module sps_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din_s
);
  logic [STAGES-1:0] sclk_q, cs_q, din_q;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      din_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk};
      cs_q   <= {cs_q[STAGES-2:0], cs_n};
      din_q  <= {din_q[STAGES-2:0], din};
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign cs_act    = ~cs_q[STAGES-1];
  assign din_s     = din_q[STAGES-1];
  assign sclk_rise = cs_act & sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_q[STAGES-1] & sclk_d;
endmodule

// File: rtl/sps_regfile.sv
module sps_regfile #(
  parameter int          RW       = 8,
  parameter int          DW       = 16,
  parameter int          SEL_W    = 3,
  parameter int          DATA_SEL = 3,
  parameter logic [7:0]  RST_VAL  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [RW-1:0]    wr_data,
  input  logic [RW-1:0]    cmd_byte,
  input  logic [DW-1:0]    data_word,
  output logic [DW-1:0]    rd_data
);
  localparam int NREG = 1 << SEL_W;

  logic [RW-1:0] slot_w [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i != 0 && i != DATA_SEL) begin : g_store
      logic [RW-1:0] val_q;
      logic          slot_en;
      assign slot_en = wr_en && (sel == SEL_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       val_q <= RST_VAL[RW-1:0];
        else if (slot_en) val_q <= wr_data;
      end
      assign slot_w[i] = val_q;
    end else begin : g_none
      assign slot_w[i] = '0;
    end
  end

  always_comb begin
    if (sel == SEL_W'(DATA_SEL))
      rd_data = data_word;
    else if (sel == '0)
      rd_data = {cmd_byte, {(DW-RW){1'b0}}};
    else
      rd_data = {slot_w[sel], {(DW-RW){1'b0}}};
  end
endmodule

// File: rtl/sps_ready.sv
module sps_ready #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data,
  input  logic          rd_done,
  output logic [DW-1:0] data_word,
  output logic          drdy_n,
  output logic          upd_pend
);
  logic [DW-1:0] hold_q, hold_n, data_q, data_n;
  logic          upd_q, upd_n, flag_q, flag_n;

  always_comb begin
    hold_n = hold_q;
    data_n = data_q;
    upd_n  = upd_q;
    flag_n = flag_q;
    if (upd_q) begin
      data_n = hold_q;
      upd_n  = 1'b0;
      flag_n = 1'b0;
    end else if (rd_done) begin
      flag_n = 1'b1;
    end
    if (conv_valid) begin
      hold_n = conv_data;
      upd_n  = 1'b1;
      flag_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      data_q <= '0;
      upd_q  <= 1'b0;
      flag_q <= 1'b1;
    end else begin
      hold_q <= hold_n;
      data_q <= data_n;
      upd_q  <= upd_n;
      flag_q <= flag_n;
    end
  end

  assign data_word = data_q;
  assign drdy_n    = flag_q;
  assign upd_pend  = upd_q;
endmodule

// File: rtl/sps_engine.sv
module sps_engine
  import sps_pkg::*;
#(
  parameter int RW       = 8,
  parameter int DW       = 16,
  parameter int SEL_W    = 3,
  parameter int DATA_SEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             din_s,
  input  logic [DW-1:0]    rd_data,
  output logic [SEL_W-1:0] sel,
  output logic [RW-1:0]    cmd_byte,
  output logic             wr_en,
  output logic [RW-1:0]    wr_data,
  output logic             rd_done,
  output logic             dout,
  output logic             dout_oe,
  output sps_state_e       state
);
  localparam int CNT_W = $clog2(DW);

  sps_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, last_cnt;
  logic [RW-2:0]    rx_q, rx_n;
  logic [RW-1:0]    rx_nx;
  logic [DW-1:0]    tx_q, tx_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic [RW-1:0]    cmd_q, cmd_n;

  assign rx_nx    = {rx_q, din_s};
  assign last_cnt = (sel_q == SEL_W'(DATA_SEL)) ? CNT_W'(DW-1) : CNT_W'(RW-1);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    sel_n   = sel_q;
    cmd_n   = cmd_q;
    wr_en   = 1'b0;
    rd_done = 1'b0;
    if (!cs_act) begin
      state_n = ST_CMD;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_CMD: if (sclk_rise) begin
          rx_n = rx_nx[RW-2:0];
          if (cnt_q == CNT_W'(RW-1)) begin
            cnt_n = '0;
            if (!rx_nx[RW-1]) begin
              cmd_n   = rx_nx;
              sel_n   = rx_nx[6:4];
              state_n = rx_nx[3] ? ST_LOAD : ST_WR;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_LOAD: begin
          tx_n    = rd_data;
          cnt_n   = '0;
          state_n = ST_RD;
        end
        ST_WR: if (sclk_rise) begin
          rx_n = rx_nx[RW-2:0];
          if (cnt_q == last_cnt) begin
            wr_en   = 1'b1;
            cnt_n   = '0;
            state_n = ST_CMD;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_RD: begin
          if (sclk_fall && cnt_q != '0) tx_n = {tx_q[DW-2:0], 1'b0};
          if (sclk_rise) begin
            if (cnt_q == last_cnt) begin
              rd_done = (sel_q == SEL_W'(DATA_SEL));
              cnt_n   = '0;
              state_n = ST_CMD;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        default: state_n = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      sel_q   <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      sel_q   <= sel_n;
      cmd_q   <= cmd_n;
    end
  end

  assign sel      = sel_q;
  assign cmd_byte = cmd_q;
  assign wr_data  = rx_nx;
  assign dout     = tx_q[DW-1];
  assign dout_oe  = cs_act & (state_q == ST_RD);
  assign state    = state_q;
endmodule

// File: rtl/sps_top.sv
module sps_top
  import sps_pkg::*;
#(
  parameter int RW       = 8,
  parameter int DW       = 16,
  parameter int SEL_W    = 3,
  parameter int DATA_SEL = 3,
  parameter int STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  output logic          drdy_n,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data
);
  logic             rst_meta, rst_sync_n;
  logic             cs_act, sclk_rise, sclk_fall, din_s;
  logic [DW-1:0]    rd_data, data_word;
  logic [SEL_W-1:0] sel;
  logic [RW-1:0]    cmd_byte, wr_data;
  logic             wr_en, rd_done, upd_pend;
  sps_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sps_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s)
  );

  sps_engine #(.RW(RW), .DW(DW), .SEL_W(SEL_W), .DATA_SEL(DATA_SEL)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .din_s(din_s), .rd_data(rd_data), .sel(sel),
    .cmd_byte(cmd_byte), .wr_en(wr_en), .wr_data(wr_data), .rd_done(rd_done),
    .dout(dout), .dout_oe(dout_oe), .state(state)
  );

  sps_regfile #(.RW(RW), .DW(DW), .SEL_W(SEL_W), .DATA_SEL(DATA_SEL)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .cmd_byte(cmd_byte), .data_word(data_word), .rd_data(rd_data)
  );

  sps_ready #(.DW(DW)) u_ready (
    .clk(clk), .rst_n(rst_sync_n), .conv_valid(conv_valid), .conv_data(conv_data),
    .rd_done(rd_done), .data_word(data_word), .drdy_n(drdy_n), .upd_pend(upd_pend)
  );
endmodule

// File: rtl/sps_top_chk.sv
module sps_top_chk
  import sps_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          sclk_fall,
  input logic          conv_valid,
  input logic          rd_done,
  input logic          upd_pend,
  input logic          drdy_n,
  input logic          dout,
  input logic [DW-1:0] data_word,
  input sps_state_e    state
);
  // R7: the data register moves only after a cycle with the flag high
  p_update_behind_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_word != $past(data_word)) |-> $past(drdy_n));

  // R7: a finished update leaves the flag low unless another load is queued
  p_flag_low_after_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_word != $past(data_word)) && !upd_pend) |-> !drdy_n);

  // R8: a completed data read raises the flag
  p_read_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !upd_pend && !conv_valid) |=> drdy_n);

  // R9: an idle chip select returns the engine to command decode
  p_idle_cs_command_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (state == ST_CMD));

  // R4: within a read, dout moves only after a falling serial edge
  p_dout_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD) && ($past(state) == ST_RD) && !$past(sclk_fall)) |-> $stable(dout));
endmodule

bind sps_top sps_top_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .conv_valid(conv_valid), .rd_done(rd_done), .upd_pend(upd_pend),
  .drdy_n(drdy_n), .dout(dout), .data_word(data_word), .state(state)
);

// File: tb/sps_top_tb.sv
module sps_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din, conv_valid;
  logic [15:0] conv_data;
  logic        dout, dout_oe, drdy_n;
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  shadow [8];
  logic [15:0] last_conv;

  always #5 clk = ~clk;

  sps_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .drdy_n(drdy_n),
    .conv_valid(conv_valid), .conv_data(conv_data)
  );

  function automatic logic [7:0] cmd_of(input logic [2:0] s, input logic rd);
    return {1'b0, s, rd, 3'b000};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [15:0] wv, output logic [15:0] rv);
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      din = wv[i];
      wait_n(8);
      sclk = 1'b1;
      rv[i] = dout;
      wait_n(8);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    wait_n(4);
  endtask

  task automatic cs_off();
    wait_n(8);
    cs_n = 1'b1;
    wait_n(6);
  endtask

  task automatic wr_reg(input logic [2:0] s, input int n, input logic [15:0] v);
    logic [15:0] rv;
    cs_on();
    xfer(8, {8'h00, cmd_of(s, 1'b0)}, rv);
    xfer(n, v, rv);
    cs_off();
  endtask

  task automatic rd_reg(input logic [2:0] s, input int n, output logic [15:0] v);
    logic [15:0] rv;
    cs_on();
    xfer(8, {8'h00, cmd_of(s, 1'b1)}, rv);
    chk("R4 oe during read", {15'd0, dout_oe}, 16'd1);
    xfer(n, 16'h0000, v);
    cs_off();
    chk("R4 oe after frame", {15'd0, dout_oe}, 16'd0);
  endtask

  task automatic load_conv(input logic [15:0] v);
    conv_data  = v;
    conv_valid = 1'b1;
    wait_n(1);
    conv_valid = 1'b0;
    chk("R7 flag high during update", {15'd0, drdy_n}, 16'd1);
    wait_n(1);
    chk("R7 flag low after update", {15'd0, drdy_n}, 16'd0);
    last_conv = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rv, tmp;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
    conv_valid = 1'b0; conv_data = '0; last_conv = '0;
    for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R1: reset state and first byte decoded as a command
    chk("R1 drdy_n after reset", {15'd0, drdy_n}, 16'd1);
    chk("R1 dout_oe after reset", {15'd0, dout_oe}, 16'd0);
    wr_reg(3'd1, 8, 16'h00A5); shadow[1] = 8'hA5;
    rd_reg(3'd1, 8, rv);
    chk("R1 first byte is command", rv, 16'h00A5);

    // R3: random writes and reads of the byte slots
    for (int k = 0; k < 40; k++) begin
      logic [2:0] ws, rs;
      logic [7:0] val;
      ws  = 3'($urandom_range(1, 6)); if (ws >= 3'd3) ws = ws + 3'd1;
      rs  = 3'($urandom_range(1, 6)); if (rs >= 3'd3) rs = rs + 3'd1;
      val = 8'($urandom);
      wr_reg(ws, 8, {8'h00, val}); shadow[ws] = val;
      rd_reg(rs, 8, rv);
      chk("R3 slot readback", rv, {8'h00, shadow[rs]});
    end
    for (int s = 1; s < 8; s++) begin
      if (s != 3) begin
        rd_reg(3'(s), 8, rv);
        chk("R3 slot sweep", rv, {8'h00, shadow[s]});
      end
    end

    // R5: slot 0 returns its own command byte
    rd_reg(3'd0, 8, rv);
    chk("R5 command readback", rv, {8'h00, cmd_of(3'd0, 1'b1)});

    // R2: a byte with bit 7 set is dropped
    cs_on();
    xfer(8, 16'h00A8, rv);
    chk("R2 bad command no oe", {15'd0, dout_oe}, 16'd0);
    xfer(8, {8'h00, cmd_of(3'd2, 1'b1)}, rv);
    xfer(8, 16'h0000, rv);
    cs_off();
    chk("R2 next byte is command", rv, {8'h00, shadow[2]});

    // R7 / R6: loads and data register reads
    load_conv(16'h1234);
    load_conv(16'hBEEF);
    rd_reg(3'd3, 16, rv);
    chk("R6 data read", rv, 16'hBEEF);
    chk("R8 flag after full read", {15'd0, drdy_n}, 16'd1);

    // R6: a write to the data register is ignored
    load_conv(16'h5A0F);
    wr_reg(3'd3, 16, 16'hFFFF);
    chk("R6 write ignored flag", {15'd0, drdy_n}, 16'd0);
    rd_reg(3'd3, 16, rv);
    chk("R6 write ignored data", rv, 16'h5A0F);

    // R8: an aborted data read leaves the flag low
    load_conv(16'h0F0F);
    cs_on();
    xfer(8, {8'h00, cmd_of(3'd3, 1'b1)}, rv);
    xfer(8, 16'h0000, rv);
    cs_off();
    chk("R8 aborted read keeps flag", {15'd0, drdy_n}, 16'd0);
    rd_reg(3'd3, 16, rv);
    chk("R8 data after abort", rv, 16'h0F0F);
    chk("R8 flag after completed read", {15'd0, drdy_n}, 16'd1);

    // R9: chip select raised mid-byte
    cs_on();
    xfer(4, 16'h0001, rv);
    cs_off();
    chk("R9 oe after abort", {15'd0, dout_oe}, 16'd0);
    rd_reg(3'd5, 8, rv);
    chk("R9 command after abort", rv, {8'h00, shadow[5]});

    // R10: several accesses within one chip select window
    cs_on();
    xfer(8, {8'h00, cmd_of(3'd6, 1'b0)}, tmp);
    xfer(8, 16'h003C, tmp); shadow[6] = 8'h3C;
    xfer(8, {8'h00, cmd_of(3'd6, 1'b1)}, tmp);
    xfer(8, 16'h0000, rv);
    chk("R10 back to back first", rv, 16'h003C);
    xfer(8, {8'h00, cmd_of(3'd1, 1'b1)}, tmp);
    xfer(8, 16'h0000, rv);
    cs_off();
    chk("R10 back to back second", rv, {8'h00, shadow[1]});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule